// File: doc/BRIEF.md
# Software Access Port for a Four-Way Translation Buffer Store

This block holds the entries of a four-way, set-associative translation buffer and gives privileged software direct load/store access to them through two 32-bit bus windows. One window reaches the tag half of every entry: the virtual page number, the address-space identifier and the valid flag. The other reaches the attribute half: the physical page number, the protection, page-size, cacheable, dirty and shared flags, and the same valid flag. There is a single stored valid bit per entry, visible through both windows.

A bus request carries an address, a write flag, write data, an access size and a privilege flag. The block decodes the window from the top address byte. It takes the set from a five-bit field and the way from a two-bit field of the address. It then stores the write word into the selected half of the entry, or returns the selected half formatted as a 32-bit word one clock later. When the hash control input is set, the set index is the XOR of the address set field with the low five bits of the current address-space identifier. A synchronous reset invalidates every entry and keeps all other stored fields.

Top module: `tlbw_top`

## Requirements
- R1: A request whose address bits 31:24 are 0xF2 reaches the tag window and 0xF3 the attribute window; any other value produces no response (`rsp_valid` stays 0) and changes no entry.
- R2: Address bits 16:12 select one of 32 sets and bits 9:8 select one of four ways; a write to one set and way leaves every other entry unchanged.
- R3: With `hash_en` set, the set used is address bits 16:12 XOR `cur_asid[4:0]`; with `hash_en` clear it is address bits 16:12 unchanged. The same selection applies to both windows.
- R4: Tag word layout: VPN in bits 31:10, valid in bit 8, ASID in bits 7:0. A tag-window write stores these fields; a tag-window read returns them with all other bits zero.
- R5: Attribute word layout: PPN in bits 28:10, valid in bit 8, protection in bits 6:5, size in bit 4, cacheable in bit 3, dirty in bit 2, shared in bit 1. An attribute-window write stores these fields; a read returns them with all other bits zero.
- R6: The valid bit is one stored bit per entry: a write through either window sets it from bit 8 of the write word, and a read through either window reports it.
- R7: Only `req_size` = 2 (longword; 0 is byte, 1 is halfword, 3 is undefined) from `req_priv` = 1 is accepted. Any other window access changes no entry, and its response has `rsp_err` = 1 and `rsp_rdata` = 0.
- R8: Every window request gets exactly one response in the clock after it; a write response carries data 0 and no error. A read issued in the clock right after a write to the same entry returns the written contents.
- R9: A synchronous reset clears the valid bit of every entry and leaves the VPN, ASID, PPN and attribute fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | 32 | Bus address |
| req_wdata | input | 32 | Store data |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 longword |
| req_priv | input | 1 | Requester is privileged |
| hash_en | input | 1 | Hash the set index with the current ASID |
| cur_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Response for last cycle's window request |
| rsp_err | output | 1 | Response is a rejected access |
| rsp_rdata | output | 32 | Load data, zero for stores and rejected accesses |

## Verification
The hardest case to reach is one stored valid bit seen from two windows at once, together with a reset that must clear it while keeping the neighbouring fields of the same entry. The stimulus writes an entry's tag half with valid clear, then its attribute half with valid set, and reads the tag half back. It then clears valid through the tag window and reads the attribute half. Reset is applied in the middle of the run, after which both halves are read to show the cleared flag beside the kept page numbers and identifier. The hashed index is reached by writing with the hash on and reading the same entry back with the hash off at the XORed set number.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

    localparam int NUM_WAYS = 4;
    localparam int SET_W    = 5;
    localparam int WAY_W    = $clog2(NUM_WAYS);
    localparam int VPN_W    = 22;
    localparam int ASID_W   = 8;
    localparam int PPN_W    = 19;

    localparam logic [7:0] TAG_WIN  = 8'hF2;
    localparam logic [7:0] ATTR_WIN = 8'hF3;
    localparam logic [1:0] SIZE_LONG = 2'd2;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              valid;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        prot;
        logic              big;
        logic              cach;
        logic              dirty;
        logic              shr;
    } entry_t;

    typedef struct packed {
        logic             win;
        logic             attr;
        logic             ok;
        logic             bad;
        logic             wr;
        logic [SET_W-1:0] set;
        logic [WAY_W-1:0] way;
    } dec_t;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [31:0] data;
    } rsp_t;

    function automatic entry_t word_to_entry(input logic [31:0] w);
        entry_t e;
        e.vpn   = w[31:10];
        e.asid  = w[7:0];
        e.valid = w[8];
        e.ppn   = w[28:10];
        e.prot  = w[6:5];
        e.big   = w[4];
        e.cach  = w[3];
        e.dirty = w[2];
        e.shr   = w[1];
        return e;
    endfunction

    function automatic logic [31:0] tag_word(input entry_t e);
        logic [31:0] w;
        w        = '0;
        w[31:10] = e.vpn;
        w[8]     = e.valid;
        w[7:0]   = e.asid;
        return w;
    endfunction

    function automatic logic [31:0] attr_word(input entry_t e);
        logic [31:0] w;
        w        = '0;
        w[28:10] = e.ppn;
        w[8]     = e.valid;
        w[6:5]   = e.prot;
        w[4]     = e.big;
        w[3]     = e.cach;
        w[2]     = e.dirty;
        w[1]     = e.shr;
        return w;
    endfunction

endpackage

// File: rtl/tlbw_decode.sv
module tlbw_decode
    import tlbw_pkg::*;
(
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic        req_priv,
    input  logic        hash_en,
    input  logic [7:0]  cur_asid,
    output dec_t        dec
);
    logic is_tag;
    logic is_attr;
    logic legal;
    logic [SET_W-1:0] raw_set;
    logic unused_bits;

    assign unused_bits = ^{req_addr[23:17], req_addr[11:10], req_addr[7:0], cur_asid[7:SET_W]};

    always_comb begin
        is_tag  = req_valid && (req_addr[31:24] == TAG_WIN);
        is_attr = req_valid && (req_addr[31:24] == ATTR_WIN);
        legal   = (req_size == SIZE_LONG) && req_priv;
        raw_set = req_addr[16:12];

        dec      = '0;
        dec.win  = is_tag || is_attr;
        dec.attr = is_attr;
        dec.ok   = dec.win && legal;
        dec.bad  = dec.win && !legal;
        dec.wr   = req_write;
        dec.way  = req_addr[9:8];
        dec.set  = hash_en ? (raw_set ^ cur_asid[SET_W-1:0]) : raw_set;
    end
endmodule

// File: rtl/tlbw_way.sv
module tlbw_way
    import tlbw_pkg::*;
#(
    parameter int SETS = 32,
    localparam int SW  = $clog2(SETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_tag,
    input  logic          we_attr,
    input  logic [SW-1:0] set,
    input  entry_t        wr_ent,
    output entry_t        rd_ent
);
    entry_t mem_q [SETS];
    entry_t mem_d [SETS];
    logic [SETS-1:0] valid_vec;

    always_comb begin
        for (int i = 0; i < SETS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_tag) begin
            mem_d[set].vpn   = wr_ent.vpn;
            mem_d[set].asid  = wr_ent.asid;
            mem_d[set].valid = wr_ent.valid;
        end
        if (we_attr) begin
            mem_d[set].ppn   = wr_ent.ppn;
            mem_d[set].prot  = wr_ent.prot;
            mem_d[set].big   = wr_ent.big;
            mem_d[set].cach  = wr_ent.cach;
            mem_d[set].dirty = wr_ent.dirty;
            mem_d[set].shr   = wr_ent.shr;
            mem_d[set].valid = wr_ent.valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                mem_q[i].valid <= 1'b0;
            end
        end else begin
            for (int i = 0; i < SETS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_ent = mem_q[set];

    always_comb begin
        for (int i = 0; i < SETS; i++) begin
            valid_vec[i] = mem_q[i].valid;
        end
    end

    // R9
    reset_clears_valid_chk: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0));

    // R7
    idle_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_tag || we_attr) |=> $stable(valid_vec));

    // R6
    write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_tag || we_attr) |=> (rd_ent.valid == $past(wr_ent.valid)) || (set != $past(set)));
endmodule

// File: rtl/tlbw_rdfmt.sv
module tlbw_rdfmt
    import tlbw_pkg::*;
#(
    parameter int WAYS = NUM_WAYS,
    localparam int WW  = $clog2(WAYS)
) (
    input  entry_t [WAYS-1:0] ents,
    input  logic   [WW-1:0]   way,
    input  logic              attr,
    output logic   [31:0]     word
);
    entry_t sel;

    always_comb begin
        sel  = ents[way];
        word = attr ? attr_word(sel) : tag_word(sel);
    end
endmodule

// File: rtl/tlbw_top.sv
module tlbw_top
    import tlbw_pkg::*;
#(
    parameter int WAYS = NUM_WAYS,
    parameter int SETS = 1 << SET_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [1:0]  req_size,
    input  logic        req_priv,
    input  logic        hash_en,
    input  logic [7:0]  cur_asid,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata
);
    dec_t   dec;
    entry_t wr_ent;
    entry_t [WAYS-1:0] rd_ents;
    logic   [WAYS-1:0] we_tag;
    logic   [WAYS-1:0] we_attr;
    logic   [31:0]     rd_word;
    rsp_t   rsp_d, rsp_q;

    tlbw_decode u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_priv  (req_priv),
        .hash_en   (hash_en),
        .cur_asid  (cur_asid),
        .dec       (dec)
    );

    assign wr_ent = word_to_entry(req_wdata);

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign we_tag[w]  = dec.ok && dec.wr && !dec.attr && (dec.way == w[WAY_W-1:0]);
            assign we_attr[w] = dec.ok && dec.wr &&  dec.attr && (dec.way == w[WAY_W-1:0]);

            tlbw_way #(.SETS(SETS)) u_way (
                .clk     (clk),
                .rst_n   (rst_n),
                .we_tag  (we_tag[w]),
                .we_attr (we_attr[w]),
                .set     (dec.set),
                .wr_ent  (wr_ent),
                .rd_ent  (rd_ents[w])
            );
        end
    endgenerate

    tlbw_rdfmt #(.WAYS(WAYS)) u_fmt (
        .ents (rd_ents),
        .way  (dec.way),
        .attr (dec.attr),
        .word (rd_word)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = dec.win;
        rsp_d.err   = dec.bad;
        rsp_d.data  = (dec.ok && !dec.wr) ? rd_word : 32'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.data;

    // R1
    window_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[31:24] == 8'hF2 || req_addr[31:24] == 8'hF3)) |=> rsp_valid);

    // R1
    outside_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && (req_addr[31:24] == 8'hF2 || req_addr[31:24] == 8'hF3)) |=> !rsp_valid);

    // R7
    reject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_size != 2'd2 || !req_priv)) |-> (we_tag == '0 && we_attr == '0));

    // R7
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

    // R2
    single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_tag, we_attr}));
endmodule

// File: tb/tb_tlbw_top.sv
`timescale 1ns/1ps
module tb_tlbw_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_size = 2'd2;
    logic        req_priv = 1'b1;
    logic        hash_en = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tlbw_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_size  (req_size),
        .req_priv  (req_priv),
        .hash_en   (hash_en),
        .cur_asid  (cur_asid),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    typedef struct {
        bit          rsp;
        bit          err;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic [31:0] taddr(input int set, input int way);
        return 32'hF200_0000 | (32'(set) << 12) | (32'(way) << 8);
    endfunction
    function automatic logic [31:0] aaddr(input int set, input int way);
        return 32'hF300_0000 | (32'(set) << 12) | (32'(way) << 8);
    endfunction
    function automatic logic [31:0] tword(input logic [21:0] vpn, input bit v, input logic [7:0] asid);
        return {vpn, 1'b0, v, asid};
    endfunction
    function automatic logic [31:0] aword(input logic [18:0] ppn, input bit v, input logic [1:0] pr,
                                          input bit sz, input bit c, input bit d, input bit sh);
        return {3'b000, ppn, 1'b0, v, 1'b0, pr, sz, c, d, sh, 1'b0};
    endfunction

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                          input logic [1:0] sz, input bit pr, input bit exp_rsp,
                          input bit exp_err, input logic [31:0] exp_d, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        req_size  = sz;
        req_priv  = pr;
        e.rsp = exp_rsp; e.err = exp_err; e.data = exp_d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr_ok(input logic [31:0] a, input logic [31:0] wd, input string tag);
        access(1'b1, a, wd, 2'd2, 1'b1, 1'b1, 1'b0, 32'd0, tag);
    endtask

    task automatic rd_ok(input logic [31:0] a, input logic [31:0] exp_d, input string tag);
        access(1'b0, a, 32'd0, 2'd2, 1'b1, 1'b1, 1'b0, exp_d, tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (rsp_valid !== e.rsp ||
                    (e.rsp && (rsp_err !== e.err || rsp_rdata !== e.data))) begin
                    fails++;
                    $display("FAIL %s: valid=%0b err=%0b data=%h expected valid=%0b err=%0b data=%h",
                             e.tag, rsp_valid, rsp_err, rsp_rdata, e.rsp, e.err, e.data);
                end
            end else if (rst_n && rsp_valid) begin
                checks++;
                fails++;
                $display("FAIL R8: unexpected response valid=%0b expected 0", rsp_valid);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
            fails++;
            $display("FAIL R8: reset outputs valid=%0b err=%0b expected 0 0", rsp_valid, rsp_err);
        end

        // R4: tag write with stray bit 9, read back masked
        wr_ok(taddr(3, 0), tword(22'h12345, 1'b1, 8'h5A) | 32'h0000_0200, "R4");
        rd_ok(taddr(3, 0), tword(22'h12345, 1'b1, 8'h5A), "R4");
        // R2: other ways and sets stay separate
        wr_ok(taddr(3, 2), tword(22'h3A5A5, 1'b1, 8'hC0), "R2");
        wr_ok(taddr(31, 0), tword(22'h00001, 1'b0, 8'hFF), "R2");
        rd_ok(taddr(3, 0), tword(22'h12345, 1'b1, 8'h5A), "R2");
        rd_ok(taddr(3, 2), tword(22'h3A5A5, 1'b1, 8'hC0), "R2");
        rd_ok(taddr(31, 0), tword(22'h00001, 1'b0, 8'hFF), "R2");

        // R5 / R6: shared valid bit through both windows
        wr_ok(taddr(5, 1), tword(22'h0ABCD, 1'b0, 8'h11), "R6");
        wr_ok(aaddr(5, 1), aword(19'h4ABCD, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1) | 32'hE000_0281, "R5");
        rd_ok(aaddr(5, 1), aword(19'h4ABCD, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1), "R5");
        rd_ok(taddr(5, 1), tword(22'h0ABCD, 1'b1, 8'h11), "R6");
        wr_ok(taddr(5, 1), tword(22'h0ABCD, 1'b0, 8'h11), "R6");
        rd_ok(aaddr(5, 1), aword(19'h4ABCD, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1), "R6");

        // R3: hashed index (5 ^ 6 = 3; 31 ^ 6 = 25)
        idle(0);
        hash_en  = 1'b1;
        cur_asid = 8'hE6;
        rd_ok(taddr(5, 0), tword(22'h12345, 1'b1, 8'h5A), "R3");
        wr_ok(taddr(31, 3), tword(22'h3FFFF, 1'b1, 8'hC3), "R3");
        idle(0);
        hash_en = 1'b0;
        rd_ok(taddr(25, 3), tword(22'h3FFFF, 1'b1, 8'hC3), "R3");

        // R7: rejected accesses
        access(1'b1, taddr(3, 0), 32'd0, 2'd0, 1'b1, 1'b1, 1'b1, 32'd0, "R7");
        access(1'b1, taddr(3, 0), 32'd0, 2'd1, 1'b1, 1'b1, 1'b1, 32'd0, "R7");
        access(1'b0, taddr(3, 0), 32'd0, 2'd2, 1'b0, 1'b1, 1'b1, 32'd0, "R7");
        access(1'b1, aaddr(5, 1), 32'd0, 2'd2, 1'b0, 1'b1, 1'b1, 32'd0, "R7");
        rd_ok(taddr(3, 0), tword(22'h12345, 1'b1, 8'h5A), "R7");
        rd_ok(aaddr(5, 1), aword(19'h4ABCD, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1), "R7");

        // R1: addresses outside both windows
        access(1'b1, 32'hF400_3000, 32'd0, 2'd2, 1'b1, 1'b0, 1'b0, 32'd0, "R1");
        access(1'b1, 32'h7200_3000, 32'd0, 2'd2, 1'b1, 1'b0, 1'b0, 32'd0, "R1");
        access(1'b0, 32'hF100_3000, 32'd0, 2'd2, 1'b1, 1'b0, 1'b0, 32'd0, "R1");
        rd_ok(taddr(3, 0), tword(22'h12345, 1'b1, 8'h5A), "R1");

        // R8: read right after write to the same entry
        wr_ok(taddr(7, 2), tword(22'h2468A, 1'b1, 8'h77), "R8");
        rd_ok(taddr(7, 2), tword(22'h2468A, 1'b1, 8'h77), "R8");
        wr_ok(aaddr(7, 2), aword(19'h13579, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0), "R8");
        rd_ok(aaddr(7, 2), aword(19'h13579, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0), "R8");

        // R9: reset clears valid only
        idle(2);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_ok(taddr(3, 0), tword(22'h12345, 1'b0, 8'h5A), "R9");
        rd_ok(taddr(7, 2), tword(22'h2468A, 1'b0, 8'h77), "R9");
        rd_ok(aaddr(7, 2), aword(19'h13579, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0), "R9");
        rd_ok(taddr(25, 3), tword(22'h3FFFF, 1'b0, 8'hC3), "R9");
        idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule